// File: doc/BRIEF.md
# LCD Controller Command Decoder and Bitmap Addressing

This block sits behind the host bus of a dot-matrix LCD controller. Each host access is a one-cycle pulse carrying an address-select bit (command or display data), a read/write bit and a byte. The block decodes command bytes into the controller's control state: display enable, segment order reversal, static drive, duty, read-modify-write mode, display start line, page and column. It exposes that state to a separate scan generator.

Display data accesses become strobes and addresses for an external 80-column by 32-line bitmap RAM. The RAM is arranged as 4 pages, each holding one 8-bit byte per column. The column advances after each access. The block also returns RAM read data and assembles a packed status byte for status reads. Both come back on a single read-return port one cycle after the read pulse.

Top module: `lcd_cmd_ctrl`

## Requirements
- R1: After hardware reset: display off, forward segment order, static drive off, 1/16 duty, read-modify-write off, start line 0, page 0, column 0, and no read return pending.
- R2: Command bytes 0xAE/0xAF clear/set display enable. 0xA0/0xA1 select forward/reversed segment order. 0xA4/0xA5 clear/set static drive. 0xA8/0xA9 select 1/16 or 1/32 duty. Any command byte with no defined meaning (for example 0xFF or 0xE1) changes no output.
- R3: A command byte 110xxxxx loads its low 5 bits into the display start line.
- R4: A command byte 101110xx loads its low 2 bits into the page. A byte 0xxxxxxx loads its low 7 bits into the column, and values above 79 load 79. The column never exceeds 79.
- R5: A data write raises the RAM write strobe in the same cycle. The current page and column and the data byte are presented with it, and the column then advances by one.
- R6: A data read raises the RAM read strobe in the same cycle, with the current page and column. In the next cycle the read-return valid is high and the read-return port carries the RAM byte. The column then advances by one.
- R7: An advance from column 79 wraps the column to 0.
- R8: Command 0xE0 enters read-modify-write mode and records the current column. In this mode data reads leave the column unchanged, and data writes still advance it.
- R9: Command 0xEE leaves read-modify-write mode and restores the column recorded on entry. Outside the mode it has no effect.
- R10: Command 0xE2 clears start line, page and column. Display enable, segment order, static drive, duty and read-modify-write mode are kept. The reset flag and busy flag are then set for RST_CYCLES cycles.
- R11: A status read returns one cycle later a byte with busy on bit 7, forward segment order (1 = forward) on bit 6, display off (1 = off) on bit 5, reset-in-progress on bit 4, and 0 on bits 3..0. Busy is also set in the cycle that immediately follows any data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | One-cycle host access pulse |
| bus_a0_i | input | 1 | 1 = display data, 0 = command/status |
| bus_rd_i | input | 1 | 1 = read, 0 = write |
| bus_data_i | input | 8 | Write byte from host |
| rd_valid_o | output | 1 | Read-return byte valid |
| rd_data_o | output | 8 | Status byte or RAM byte for the host |
| ram_page_o | output | 2 | Bitmap page address |
| ram_col_o | output | 7 | Bitmap column address |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| ram_wdata_o | output | 8 | RAM write byte |
| ram_rdata_i | input | 8 | RAM read byte, one cycle after ram_re_o |
| start_line_o | output | 5 | Display start line for the scan generator |
| disp_on_o | output | 1 | Display enable |
| seg_rev_o | output | 1 | Reversed segment order |
| static_drv_o | output | 1 | Static drive |
| duty32_o | output | 1 | 1 = 1/32 duty, 0 = 1/16 |
| rmw_o | output | 1 | Read-modify-write mode active |

## Verification
The hardest state to reach is a read-modify-write session whose reads and writes are interleaved, followed by an exit that must rewind the column. It is only visible through later RAM addresses and data. The stimulus enters the mode partway along a page, alternates data reads and writes, and leaves the mode. It then reads back. The scoreboard's bench-side copy of the bitmap checks that the bytes return in the order the rewind implies. The busy flag after a data access lasts one cycle, so a status read is issued back-to-back with a write and again one cycle later.

// File: rtl/lcd_cmd_pkg.sv
`timescale 1ns/1ps
package lcd_cmd_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_DISP, OP_START, OP_PAGE, OP_COL, OP_ADC, OP_STATIC,
    OP_DUTY, OP_RMW, OP_END, OP_RESET, OP_WDATA, OP_RDATA, OP_STATUS
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] arg;
  } cmd_t;
endpackage

// File: rtl/lcd_cmd_decode.sv
`timescale 1ns/1ps
module lcd_cmd_decode
  import lcd_cmd_pkg::*;
(
  input  logic       valid_i,
  input  logic       a0_i,
  input  logic       rd_i,
  input  logic [7:0] data_i,
  output cmd_t       cmd_o
);
  always_comb begin
    cmd_o.op  = OP_NONE;
    cmd_o.arg = data_i;
    if (valid_i) begin
      if (a0_i)      cmd_o.op = rd_i ? OP_RDATA : OP_WDATA;
      else if (rd_i) cmd_o.op = OP_STATUS;
      else begin
        casez (data_i)
          8'b0???????: cmd_o.op = OP_COL;
          8'b110?????: cmd_o.op = OP_START;
          8'b101110??: cmd_o.op = OP_PAGE;
          8'b1010111?: cmd_o.op = OP_DISP;
          8'b1010000?: cmd_o.op = OP_ADC;
          8'b1010010?: cmd_o.op = OP_STATIC;
          8'b1010100?: cmd_o.op = OP_DUTY;
          8'b11100000: cmd_o.op = OP_RMW;
          8'b11101110: cmd_o.op = OP_END;
          8'b11100010: cmd_o.op = OP_RESET;
          default:     cmd_o.op = OP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_col_ctr.sv
`timescale 1ns/1ps
module lcd_col_ctr
  import lcd_cmd_pkg::*;
#(
  parameter int unsigned NUM_COLS = 80,
  localparam int unsigned COL_W   = $clog2(NUM_COLS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic [6:0]       arg_i,
  input  logic             rmw_i,
  output logic [COL_W-1:0] col_o
);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(NUM_COLS - 1);

  logic [COL_W-1:0] col_q, save_q, col_inc, col_load;

  assign col_inc  = (col_q == COL_MAX) ? '0 : col_q + 1'b1;
  assign col_load = (arg_i > 7'(NUM_COLS - 1)) ? COL_MAX : arg_i[COL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      save_q <= '0;
    end else begin
      unique case (op_i)
        OP_COL:   col_q <= col_load;
        OP_WDATA: col_q <= col_inc;
        OP_RDATA: if (!rmw_i) col_q <= col_inc;
        OP_RESET: col_q <= '0;
        OP_RMW:   save_q <= col_q;
        OP_END:   if (rmw_i) col_q <= save_q;
        default: ;
      endcase
    end
  end

  assign col_o = col_q;

  AST_COL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= COL_MAX); // R4
  AST_COL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WDATA && col_q == COL_MAX) |=> col_q == '0); // R7
  AST_RMW_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RDATA && rmw_i) |=> $stable(col_q)); // R8
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_END && !rmw_i) |=> $stable(col_q)); // R9
endmodule

// File: rtl/lcd_ctrl_regs.sv
`timescale 1ns/1ps
module lcd_ctrl_regs
  import lcd_cmd_pkg::*;
#(
  parameter int unsigned NUM_PAGES  = 4,
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned PAGE_W    = $clog2(NUM_PAGES),
  localparam int unsigned LINE_W    = $clog2(NUM_LINES),
  localparam int unsigned CNT_W     = $clog2(RST_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [4:0]        arg_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [LINE_W-1:0] start_o,
  output logic              disp_on_o,
  output logic              seg_rev_o,
  output logic              static_o,
  output logic              duty32_o,
  output logic              rmw_o,
  output logic              busy_o,
  output logic              rst_flag_o
);
  logic [PAGE_W-1:0] page_q;
  logic [LINE_W-1:0] start_q;
  logic              on_q, rev_q, stat_q, duty_q, rmw_q, acc_q;
  logic [CNT_W-1:0]  rst_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q    <= '0;
      start_q   <= '0;
      on_q      <= 1'b0;
      rev_q     <= 1'b0;
      stat_q    <= 1'b0;
      duty_q    <= 1'b0;
      rmw_q     <= 1'b0;
      acc_q     <= 1'b0;
      rst_cnt_q <= '0;
    end else begin
      acc_q <= (op_i == OP_WDATA) || (op_i == OP_RDATA);
      if (rst_cnt_q != '0) rst_cnt_q <= rst_cnt_q - 1'b1;
      unique case (op_i)
        OP_DISP:   on_q    <= arg_i[0];
        OP_ADC:    rev_q   <= arg_i[0];
        OP_STATIC: stat_q  <= arg_i[0];
        OP_DUTY:   duty_q  <= arg_i[0];
        OP_START:  start_q <= arg_i[LINE_W-1:0];
        OP_PAGE:   page_q  <= arg_i[PAGE_W-1:0];
        OP_RMW:    rmw_q   <= 1'b1;
        OP_END:    rmw_q   <= 1'b0;
        OP_RESET: begin
          start_q   <= '0;
          page_q    <= '0;
          rst_cnt_q <= CNT_W'(RST_CYCLES);
        end
        default: ;
      endcase
    end
  end

  assign page_o     = page_q;
  assign start_o    = start_q;
  assign disp_on_o  = on_q;
  assign seg_rev_o  = rev_q;
  assign static_o   = stat_q;
  assign duty32_o   = duty_q;
  assign rmw_o      = rmw_q;
  assign rst_flag_o = (rst_cnt_q != '0);
  assign busy_o     = acc_q || (rst_cnt_q != '0);

  AST_RST_CMD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RESET) |=> (start_q == '0 && page_q == '0 && rst_flag_o)); // R10
  AST_RST_CMD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RESET) |=> ($stable(on_q) && $stable(rev_q) && $stable(stat_q)
                            && $stable(duty_q) && $stable(rmw_q))); // R10
  AST_BUSY_AFTER_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WDATA || op_i == OP_RDATA) |=> busy_o); // R11
endmodule

// File: rtl/lcd_status.sv
`timescale 1ns/1ps
module lcd_status
  import lcd_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  op_e        op_i,
  input  logic       busy_i,
  input  logic       rst_flag_i,
  input  logic       seg_rev_i,
  input  logic       disp_on_i,
  input  logic [7:0] ram_rdata_i,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o
);
  logic       vld_q, is_stat_q;
  logic [7:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q     <= 1'b0;
      is_stat_q <= 1'b0;
      stat_q    <= '0;
    end else begin
      vld_q     <= (op_i == OP_STATUS) || (op_i == OP_RDATA);
      is_stat_q <= (op_i == OP_STATUS);
      if (op_i == OP_STATUS)
        stat_q <= {busy_i, ~seg_rev_i, ~disp_on_i, rst_flag_i, 4'b0000};
    end
  end

  assign rd_valid_o = vld_q;
  assign rd_data_o  = is_stat_q ? stat_q : ram_rdata_i;

  AST_STAT_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && is_stat_q) |-> rd_data_o[3:0] == 4'b0000); // R11
  AST_READ_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RDATA) |=> (rd_valid_o && rd_data_o == ram_rdata_i)); // R6
endmodule

// File: rtl/lcd_cmd_ctrl.sv
`timescale 1ns/1ps
module lcd_cmd_ctrl
  import lcd_cmd_pkg::*;
#(
  parameter int unsigned NUM_COLS   = 80,
  parameter int unsigned NUM_PAGES  = 4,
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned COL_W     = $clog2(NUM_COLS),
  localparam int unsigned PAGE_W    = $clog2(NUM_PAGES),
  localparam int unsigned LINE_W    = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_a0_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_data_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic [PAGE_W-1:0] ram_page_o,
  output logic [COL_W-1:0]  ram_col_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i,
  output logic [LINE_W-1:0] start_line_o,
  output logic              disp_on_o,
  output logic              seg_rev_o,
  output logic              static_drv_o,
  output logic              duty32_o,
  output logic              rmw_o
);
  cmd_t cmd;
  logic busy, rst_flag, rmw;

  lcd_cmd_decode u_dec (
    .valid_i (bus_valid_i),
    .a0_i    (bus_a0_i),
    .rd_i    (bus_rd_i),
    .data_i  (bus_data_i),
    .cmd_o   (cmd)
  );

  lcd_ctrl_regs #(
    .NUM_PAGES  (NUM_PAGES),
    .NUM_LINES  (NUM_LINES),
    .RST_CYCLES (RST_CYCLES)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (cmd.op),
    .arg_i      (cmd.arg[4:0]),
    .page_o     (ram_page_o),
    .start_o    (start_line_o),
    .disp_on_o  (disp_on_o),
    .seg_rev_o  (seg_rev_o),
    .static_o   (static_drv_o),
    .duty32_o   (duty32_o),
    .rmw_o      (rmw),
    .busy_o     (busy),
    .rst_flag_o (rst_flag)
  );

  lcd_col_ctr #(.NUM_COLS(NUM_COLS)) u_col (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (cmd.op),
    .arg_i  (cmd.arg[6:0]),
    .rmw_i  (rmw),
    .col_o  (ram_col_o)
  );

  lcd_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (cmd.op),
    .busy_i      (busy),
    .rst_flag_i  (rst_flag),
    .seg_rev_i   (seg_rev_o),
    .disp_on_i   (disp_on_o),
    .ram_rdata_i (ram_rdata_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  assign ram_we_o    = (cmd.op == OP_WDATA);
  assign ram_re_o    = (cmd.op == OP_RDATA);
  assign ram_wdata_o = cmd.arg;
  assign rmw_o       = rmw;

  AST_WRITE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && ram_col_o != COL_W'(NUM_COLS - 1)) |=> ram_col_o == $past(ram_col_o) + 1'b1); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_we_o, ram_re_o})); // R5
endmodule

// File: tb/lcd_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_cmd_ctrl_tb;
  localparam int NC = 80;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       vld = 1'b0, a0 = 1'b0, rd = 1'b0;
  logic [7:0] din = '0;
  logic       rd_valid, we, re, on, rev, stat, duty, rmw;
  logic [7:0] rd_data, wdata, ram_q;
  logic [1:0] page;
  logic [6:0] col;
  logic [4:0] start;

  logic [7:0] mem    [4*NC];
  logic [7:0] shadow [4*NC];
  logic [7:0] expq[$];

  int n_chk = 0, n_fail = 0;
  int exp_col = 0, exp_page = 0, save_col = 0;
  bit exp_rmw = 0, done = 0;

  always #4 clk = ~clk;

  lcd_cmd_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(vld), .bus_a0_i(a0), .bus_rd_i(rd),
    .bus_data_i(din), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .ram_page_o(page), .ram_col_o(col), .ram_we_o(we), .ram_re_o(re),
    .ram_wdata_o(wdata), .ram_rdata_i(ram_q), .start_line_o(start),
    .disp_on_o(on), .seg_rev_o(rev), .static_drv_o(stat), .duty32_o(duty), .rmw_o(rmw)
  );

  always_ff @(posedge clk) begin
    if (we) mem[int'(page)*NC + int'(col)] <= wdata;
    if (re) ram_q <= mem[int'(page)*NC + int'(col)];
  end

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) chk(32'(rd_data), -1, "R6/R11 unexpected return");
      else chk(32'(rd_data), 32'(expq.pop_front()), "R6/R11 read return");
    end
  end

  task automatic issue(input bit a, input bit r, input logic [7:0] d);
    a0 = a; rd = r; din = d; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d); issue(0, 0, d); endtask

  task automatic status(input logic [7:0] e);
    expq.push_back(e);
    issue(0, 1, 8'h00);
  endtask

  task automatic wr_data(input logic [7:0] d);
    a0 = 1; rd = 0; din = d; vld = 1;
    #1;
    chk(32'(we), 1, "R5 write strobe");
    chk(32'(col), exp_col, "R5 write column");
    chk(32'(page), exp_page, "R5 write page");
    chk(32'(wdata), 32'(d), "R5 write data");
    shadow[exp_page*NC + exp_col] = d;
    exp_col = (exp_col == NC-1) ? 0 : exp_col + 1;
    @(negedge clk);
    vld = 0;
  endtask

  task automatic rd_data_t();
    a0 = 1; rd = 1; din = 8'h00; vld = 1;
    #1;
    chk(32'(re), 1, "R6 read strobe");
    chk(32'(col), exp_col, "R6 read column");
    expq.push_back(shadow[exp_page*NC + exp_col]);
    if (!exp_rmw) exp_col = (exp_col == NC-1) ? 0 : exp_col + 1;
    @(negedge clk);
    vld = 0;
  endtask

  task automatic set_col(input int c);
    cmd(8'(c));
    exp_col = (c > NC-1) ? NC-1 : c;
    chk(32'(col), exp_col, "R4 column load");
  endtask

  initial begin
    for (int i = 0; i < 4*NC; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({on, rev, stat, duty, rmw, rd_valid}, 0, "R1 mode bits");
    chk({25'd0, page, col}, 0, "R1 page/column");
    chk(32'(start), 0, "R1 start line");
    status(8'h60); // R11 off + forward

    // R2 mode commands
    cmd(8'hAF); chk(32'(on), 1, "R2 display on");
    cmd(8'hA1); chk(32'(rev), 1, "R2 reversed");
    cmd(8'hA5); chk(32'(stat), 1, "R2 static on");
    cmd(8'hA9); chk(32'(duty), 1, "R2 duty 1/32");
    cmd(8'hA4); chk(32'(stat), 0, "R2 static off");
    cmd(8'hFF); cmd(8'hE1);
    chk({on, rev, stat, duty, rmw}, 5'b11010, "R2 undefined ignored");
    chk(32'(col), 0, "R2 undefined column kept");
    status(8'h00); // R11

    // R3 start line
    cmd(8'hDB); chk(32'(start), 27, "R3 start line");
    // R4 page and column
    cmd(8'hBA); exp_page = 2; chk(32'(page), 2, "R4 page");
    set_col(8'h7F); // R4 clamp
    set_col(8'h50);
    set_col(10);

    // R5 writes, then R11 busy after access
    wr_data(8'hAA);
    wr_data(8'hBB);
    status(8'h80);
    status(8'h00);
    chk(32'(col), 12, "R5 column advanced");

    // R6 reads
    set_col(10);
    rd_data_t(); rd_data_t();
    @(negedge clk);
    chk(32'(col), 12, "R6 column advanced");

    // R7 wrap
    set_col(78);
    wr_data(8'h11); wr_data(8'h22);
    chk(32'(col), 0, "R7 wrap after write");
    set_col(79);
    rd_data_t();
    @(negedge clk);
    chk(32'(col), 0, "R7 wrap after read");

    // R8 read-modify-write
    set_col(5);
    cmd(8'hE0); exp_rmw = 1; save_col = 5;
    chk(32'(rmw), 1, "R8 mode entered");
    rd_data_t();
    chk(32'(col), 5, "R8 read holds column");
    wr_data(8'h33);
    rd_data_t();
    chk(32'(col), 6, "R8 read holds column");
    wr_data(8'h44);
    chk(32'(col), 7, "R8 write advances");

    // R9 end restores
    cmd(8'hEE); exp_rmw = 0; exp_col = save_col;
    chk(32'(rmw), 0, "R9 mode left");
    chk(32'(col), 5, "R9 column restored");
    rd_data_t(); rd_data_t();
    @(negedge clk);
    cmd(8'hEE);
    chk(32'(col), 7, "R9 end outside mode ignored");

    // R10 reset command
    cmd(8'hE2); exp_col = 0; exp_page = 0;
    chk({25'd0, page, col}, 0, "R10 page/column cleared");
    chk(32'(start), 0, "R10 start cleared");
    chk({on, rev, stat, duty, rmw}, 5'b11010, "R10 modes kept");
    status(8'h90); // R10 R11 busy + reset flag
    repeat (3) @(negedge clk);
    status(8'h00); // R10 flags gone after RST_CYCLES

    repeat (4) @(negedge clk);
    chk(expq.size(), 0, "R6/R11 all returns seen");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule